// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches one external interrupt pin and turns qualifying activity on it into a sticky event flag and an interrupt request. Software chooses the active polarity and whether only the active edge counts, or the active edge together with the pin being held at its active level. The pin is first passed through a synchroniser. Edges are found by comparing each synchronised sample with the one before it.

Configuration and status share one 8-bit register, reached through an address-free bus with a write strobe and a read strobe. Software polls the flag, or lets the request output follow it. It clears the flag by writing one to an acknowledge bit. The block also drives the enable and direction of the pad's pull device. The pull direction follows the chosen polarity, so an idle pin rests at its inactive level.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `irq_o` is 0 and both pull outputs are 0.
- R2: Register fields: bit 0 level mode, bit 1 request enable, bit 2 acknowledge, bit 3 event flag, bit 4 pin enable, bit 5 polarity, bit 6 pull off. Bit 7 always reads 0. Bit 2 always reads 0. A write cannot set or clear bit 3 directly.
- R3: With polarity 0 only a high-to-low transition of the pin sets the flag. With polarity 1 only a low-to-high transition sets it. The flag becomes 1 three clock edges after the pin changes.
- R4: Writing 1 to bit 2 clears the flag when no event is present. Writing 0 to bit 2 leaves the flag unchanged.
- R5: In level mode the flag is set on every cycle that the synchronised pin sits at its active level. An acknowledge therefore does not clear it until the pin has left that level.
- R6: `irq_o` is 1 exactly when the flag and the request enable are both 1.
- R7: While the pin enable is 0, no pin activity sets the flag.
- R8: `pull_en_o` is 1 when the pin enable is 1 and pull off is 0. `pull_dn_o` is 1 when `pull_en_o` is 1 and the polarity is 1; this selects a pull-down, and otherwise the pull device is a pull-up.
- R9: When an event and an acknowledge write fall on the same cycle, the flag ends at 1.
- R10: Changing the polarity, or turning the pin enable on, never produces an event by itself when the pin is steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | External interrupt pin (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Register read data; 0 when rd_en is low |
| irq_o | output | 1 | Interrupt request |
| pull_en_o | output | 1 | Pad pull device enable |
| pull_dn_o | output | 1 | Pad pull direction: 1 pull-down, 0 pull-up |

## Verification
The properties assume that the pin meets the synchroniser's timing. They also assume that the write and read strobes are single-cycle pulses with data that is stable around the clock edge. The bench changes the pin, the strobes and the data 2 ns after a rising edge and holds every pin level for at least three edges before it expects a result. It writes the register only at points where the expected flag value follows from a single rule, except in the one case where it deliberately lines up an event with an acknowledge write.

// File: rtl/extirq_ctrl.sv
module extirq_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int REG_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_o,
  output logic             pull_en_o,
  output logic             pull_dn_o
);
  localparam int B_LVL  = 0;
  localparam int B_IE   = 1;
  localparam int B_ACK  = 2;
  localparam int B_FLAG = 3;
  localparam int B_ON   = 4;
  localparam int B_POL  = 5;
  localparam int B_POFF = 6;

  logic [SYNC_STAGES-1:0] sync_q;
  logic pin_s;
  logic lvl_q, ie_q, flag_q, on_q, pol_q, poff_q;
  logic prev_q;
  logic active, edge_hit, level_hit, set_evt, ack_wr, cfg_wr;
  logic unused_bits;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};

  assign pin_s     = sync_q[SYNC_STAGES-1];
  assign active    = (pin_s == pol_q);
  assign edge_hit  = on_q && active && !prev_q;
  assign level_hit = on_q && lvl_q && active;
  assign set_evt   = edge_hit || level_hit;
  assign ack_wr    = wr_en && wr_data[B_ACK];
  assign cfg_wr    = wr_en && ((wr_data[B_POL] != pol_q) || (wr_data[B_ON] && !on_q));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      prev_q <= 1'b0;
    else if (cfg_wr) prev_q <= (pin_s == wr_data[B_POL]);
    else             prev_q <= active;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      ie_q   <= 1'b0;
      on_q   <= 1'b0;
      pol_q  <= 1'b0;
      poff_q <= 1'b0;
    end else if (wr_en) begin
      lvl_q  <= wr_data[B_LVL];
      ie_q   <= wr_data[B_IE];
      on_q   <= wr_data[B_ON];
      pol_q  <= wr_data[B_POL];
      poff_q <= wr_data[B_POFF];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (ack_wr)  flag_q <= 1'b0;

  assign irq_o     = flag_q && ie_q;
  assign pull_en_o = on_q && !poff_q;
  assign pull_dn_o = pull_en_o && pol_q;

  assign rd_data = rd_en ? {1'b0, poff_q, pol_q, on_q, flag_q, 1'b0, ie_q, lvl_q} : '0;

  assign unused_bits = ^{wr_data[REG_W-1], wr_data[B_FLAG]};
endmodule

module extirq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic ack_bit,
  input logic on_q,
  input logic lvl_q,
  input logic active,
  input logic flag_q,
  input logic ie_q,
  input logic irq_o,
  input logic pull_en_o,
  input logic pull_dn_o
);
  a_r5_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q && lvl_q && active) |=> flag_q);

  a_r7_off_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_q && !flag_q) |=> !flag_q);

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ack_bit && !on_q) |=> !flag_q);

  a_r3_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(on_q));

  a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_q && ie_q));

  a_r8_dir_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    pull_dn_o |-> pull_en_o);
endmodule

bind extirq_ctrl extirq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ack_bit(wr_data[2]),
  .on_q(on_q), .lvl_q(lvl_q), .active(active), .flag_q(flag_q),
  .ie_q(ie_q), .irq_o(irq_o), .pull_en_o(pull_en_o), .pull_dn_o(pull_dn_o)
);

// File: tb/tb_extirq_ctrl.sv
`timescale 1ns/1ps
module tb_extirq_ctrl;
  logic clk = 0, rst_n = 0, pin_i = 1, wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq_o, pull_en_o, pull_dn_o;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  extirq_ctrl dut (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_o(irq_o),
    .pull_en_o(pull_en_o), .pull_dn_o(pull_dn_o));

  always #5 clk = ~clk;

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [7:0] v);
    wr_en = 1; wr_data = v; tick(1); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1; tick(1); rd_en = 0;
  endtask

  task automatic chk(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic pin(logic v);
    pin_i = v; tick(3);
  endtask

  always @(negedge clk) if (rd_en && exp_q.size() > 0) begin
    logic [7:0] e;
    string t;
    e = exp_q.pop_front(); t = tag_q.pop_front();
    checks++;
    if (rd_data !== e) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", t, rd_data, e);
    end
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick(3);
    rd(8'h00, "R1 reset register");
    chk(irq_o, 0, "R1 irq"); chk(pull_en_o, 0, "R1 pull_en"); chk(pull_dn_o, 0, "R1 pull_dn");

    wr(8'h12); tick(2);
    rd(8'h12, "R10 enable no spurious");
    chk(pull_en_o, 1, "R8 pull up on"); chk(pull_dn_o, 0, "R8 pull up dir");
    pin(0);
    rd(8'h1A, "R3 falling edge sets");
    chk(irq_o, 1, "R6 irq asserted");
    wr(8'h1A);
    rd(8'h1A, "R2 write flag/0 ack no effect");
    wr(8'h16);
    rd(8'h12, "R4 ack clears, ack reads 0");
    chk(irq_o, 0, "R6 irq cleared");
    pin(1); tick(1);
    rd(8'h12, "R3 rising ignored pol0");
    wr(8'h90);
    rd(8'h10, "R2 bit7 reads 0");
    pin(0);
    rd(8'h18, "R6 flag polled");
    chk(irq_o, 0, "R6 irq masked");
    wr(8'h14); pin(1);

    wr(8'h00); pin(0); pin(1); pin(0);
    rd(8'h00, "R7 disabled pin ignored");
    wr(8'h12); tick(2);
    rd(8'h12, "R10 enable while low");
    pin(1); tick(1);
    wr(8'h32); tick(2);
    rd(8'h32, "R10 polarity change");
    chk(pull_dn_o, 1, "R8 pull down dir");
    pin(0); tick(1);
    rd(8'h32, "R3 falling ignored pol1");
    pin(1);
    rd(8'h3A, "R3 rising sets pol1");
    wr(8'h76);
    chk(pull_en_o, 0, "R8 pull off"); chk(pull_dn_o, 0, "R8 pull off dir");
    rd(8'h72, "R4 ack clears pol1");

    wr(8'h13); tick(1);
    pin(0);
    rd(8'h1B, "R5 level sets");
    wr(8'h17);
    rd(8'h1B, "R5 ack blocked at level");
    pin(1);
    wr(8'h17);
    rd(8'h13, "R5 ack after release");

    wr(8'h12); tick(2);
    pin_i = 0; tick(2);
    wr(8'h16);
    rd(8'h1A, "R9 set wins over ack");
    wr(8'h16); pin(1);
    rd(8'h12, "R9 later ack clears");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule